// File: doc/BRIEF.md
# DRAM Open-Page Burst Address Generator

This block produces a stream of memory request addresses meant to keep a DRAM controller working on open pages. Requests come in series. At the start of each series the block makes four random choices: a read or write direction, a bank, a rank and a starting column. It then issues the configured number of requests to consecutive columns of that one page. The column draw is limited so that no series runs past the end of its page.

Two ways of packing the DRAM fields into the byte address are supported:
- **Layout 0** (row-rank-bank-column). From the least significant bit upward: block offset, column, bank, rank.
- **Layout 1** (row-column-rank-bank). From the least significant bit upward: block offset, bank, rank, column.

The row part of the address comes from a random base address. The base is drawn inside a configured window and aligned down to the burst size.

Software loads a configuration with a single-cycle strobe. Requests leave on a valid/ready port that carries an address, a write flag and a size. A running byte total counts every accepted request. An illegal configuration raises an error flag and keeps the generator silent. A random source, a 32-bit maximal-length LFSR, advances once per draw cycle. Each draw is masked to a power-of-two width, and a value outside its range is thrown away and drawn again.

Top module: `dram_hit_gen`

## Requirements
- R1: After reset `req_valid`, `bytes_total` and `cfg_err` are 0, and no request appears until a legal configuration is loaded.
- R2: Requests come in series of `cfg_seq_len` requests. The write flag stays the same for all requests of a series.
- R3: The direction depends on the read percentage. At 0 every request is a write (`req_write`=1). At 100 every request is a read (`req_write`=0). Between those values a draw in 0..100 gives a read when it is below the percentage, so both kinds occur.
- R4: Each series uses a bank number below `cfg_banks_used`. `cfg_err` goes to 1 and `req_valid` stays 0 if any of the following holds for the loaded configuration:
  - `cfg_banks_used` is 0, or larger than `cfg_banks`;
  - `cfg_seq_len` is 0, or larger than the columns per page (page bytes / block bytes);
  - the end address is below the start address.
- R5: Each series uses a rank number below `cfg_ranks`. With a single rank, no rank field is written.
- R6: The starting column of a series is at most (columns per page − `cfg_seq_len`), so every request of the series stays in one page.
- R7: Layout 0. With b = log2(block bytes), c = log2(columns per page) and k = log2(banks): the block offset is bits [b-1:0] and is zero, the column sits at bit b, the bank at bit b+c, and the rank at bit b+c+k.
- R8: Layout 1. With r = log2(ranks): the block offset is bits [b-1:0] and is zero, the bank sits at bit b, the rank at bit b+k, and the column at bit b+k+r.
- R9: Each request after the first in a series equals the previous address with its column field raised by one. All other bits stay unchanged.
- R10: `req_size` equals the block size in bytes. `bytes_total` grows by `req_size` on every cycle with `req_valid` and `req_ready` both high.
- R11: While `req_valid` is high and `req_ready` is low, the request (valid, address, write flag) holds unchanged to the next cycle.
- R12: A configuration load abandons the series in progress. The next request starts a new series under the new settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | One-cycle strobe that captures all cfg_* inputs |
| cfg_layout | input | 1 | 0: row-rank-bank-column, 1: row-column-rank-bank |
| cfg_start | input | AW | Lowest base address |
| cfg_end | input | AW | Highest base address |
| cfg_block_bytes | input | SW | Burst size in bytes, power of two |
| cfg_page_bytes | input | SW | Page size in bytes, power of two |
| cfg_banks | input | BKW | Physical banks, power of two |
| cfg_banks_used | input | BKW | Banks the traffic may use |
| cfg_ranks | input | BKW | Ranks, power of two |
| cfg_seq_len | input | SW | Requests per series |
| cfg_read_pct | input | 7 | Read percentage, 0..100 |
| cfg_err | output | 1 | Loaded configuration is illegal |
| req_valid | output | 1 | Request available |
| req_ready | input | 1 | Consumer accepts the request |
| req_addr | output | AW | Request byte address |
| req_write | output | 1 | 1 = write, 0 = read |
| req_size | output | SW | Request size in bytes |
| bytes_total | output | CW | Bytes in accepted requests since reset |

## Verification
The hardest case to reach is a series whose page has no spare room, where the sequence length equals the number of columns per page. There the column draw must be rejected until it yields exactly zero, and the series must then fill the page to its last column. The stimulus sets the sequence length equal to the column count under layout 1 while `req_ready` stalls in a repeating pattern. Every accepted request is checked against a model that predicts each next address from the previous one. A second hard case is a reload that lands in the middle of a series. The bench waits until its model shows requests still outstanding, then loads a configuration with the opposite direction and requires the very next request to follow it.

// File: rtl/dram_hit_gen.sv
module dram_hit_gen #(
  parameter int AW = 32,
  parameter int SW = 16,
  parameter int BKW = 8,
  parameter int CW = 48,
  parameter logic [31:0] SEED = 32'h1ACE_B00C
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_load,
  input  logic           cfg_layout,
  input  logic [AW-1:0]  cfg_start,
  input  logic [AW-1:0]  cfg_end,
  input  logic [SW-1:0]  cfg_block_bytes,
  input  logic [SW-1:0]  cfg_page_bytes,
  input  logic [BKW-1:0] cfg_banks,
  input  logic [BKW-1:0] cfg_banks_used,
  input  logic [BKW-1:0] cfg_ranks,
  input  logic [SW-1:0]  cfg_seq_len,
  input  logic [6:0]     cfg_read_pct,
  output logic           cfg_err,
  output logic           req_valid,
  input  logic           req_ready,
  output logic [AW-1:0]  req_addr,
  output logic           req_write,
  output logic [SW-1:0]  req_size,
  output logic [CW-1:0]  bytes_total
);

  typedef enum logic [2:0] {S_IDLE, S_RW, S_BANK, S_RANK, S_BASE, S_COL, S_EMIT} st_t;

  function automatic logic [5:0] lg2(input logic [SW-1:0] x);
    logic [5:0] r;
    r = '0;
    for (int i = 0; i < SW; i++) if (x[i]) r = 6'(i);
    return r;
  endfunction

  function automatic logic [AW-1:0] put(input logic [AW-1:0] a, input logic [5:0] pos,
                                        input logic [5:0] w, input logic [AW-1:0] v);
    logic [AW-1:0] m;
    m = ((AW'(1) << w) - AW'(1)) << pos;
    return (a & ~m) | ((v << pos) & m);
  endfunction

  function automatic logic [AW-1:0] smear(input logic [AW-1:0] x);
    logic [AW-1:0] m;
    m = '0;
    for (int i = 0; i < AW; i++) if ((x >> i) != '0) m[i] = 1'b1;
    return m;
  endfunction

  st_t            st;
  logic [31:0]    lfsr;
  logic [5:0]     c_bb, c_cb, c_kb, c_rb;
  logic [AW-1:0]  c_start, c_span;
  logic [BKW-1:0] c_used;
  logic [SW-1:0]  c_n, c_colmax, left;
  logic [6:0]     c_pct;
  logic           c_lay;
  logic [AW-1:0]  d_base, d_bank, d_rank, addr;
  logic           wr;

  logic [5:0]    l_bb;
  logic [SW-1:0] l_cols;
  logic          l_bad;
  assign l_bb   = lg2(cfg_block_bytes);
  assign l_cols = cfg_page_bytes >> l_bb;
  assign l_bad  = cfg_banks_used == '0 || cfg_banks_used > cfg_banks || cfg_seq_len == '0 ||
                  cfg_seq_len > l_cols || cfg_end < cfg_start || cfg_block_bytes == '0;

  logic [AW-1:0] rnd, colmask, kmask, rmask, smask, base_al, first_addr, next_addr;
  logic [5:0]    colpos, bankpos, rankpos;
  assign rnd     = AW'(lfsr);
  assign colmask = (AW'(1) << c_cb) - AW'(1);
  assign kmask   = (AW'(1) << c_kb) - AW'(1);
  assign rmask   = (AW'(1) << c_rb) - AW'(1);
  assign smask   = smear(c_span);
  assign colpos  = c_lay ? c_bb + c_kb + c_rb : c_bb;
  assign bankpos = c_lay ? c_bb : c_bb + c_cb;
  assign rankpos = c_lay ? c_bb + c_kb : c_bb + c_cb + c_kb;
  assign base_al = d_base & ~((AW'(1) << c_bb) - AW'(1));
  assign first_addr = put(put(put(base_al, colpos, c_cb, rnd & colmask),
                              bankpos, c_kb, d_bank), rankpos, c_rb, d_rank);
  assign next_addr = c_lay ? put(addr, colpos, c_cb, ((addr >> colpos) & colmask) + AW'(1))
                           : addr + AW'(req_size);

  assign req_valid = (st == S_EMIT);
  assign req_addr  = addr;
  assign req_write = wr;
  assign req_size  = SW'(1) << c_bb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; lfsr <= SEED; bytes_total <= '0; cfg_err <= 1'b0;
      c_bb <= '0; c_cb <= '0; c_kb <= '0; c_rb <= '0; c_start <= '0; c_span <= '0;
      c_used <= '0; c_n <= '0; c_colmax <= '0; c_pct <= '0; c_lay <= 1'b0;
      d_base <= '0; d_bank <= '0; d_rank <= '0; addr <= '0; wr <= 1'b0; left <= '0;
    end else begin
      if (req_valid && req_ready) bytes_total <= bytes_total + CW'(req_size);
      if (st != S_IDLE && st != S_EMIT)
        lfsr <= {1'b0, lfsr[31:1]} ^ (lfsr[0] ? 32'h8020_0003 : 32'h0);
      if (cfg_load) begin
        c_bb <= l_bb; c_cb <= lg2(l_cols);
        c_kb <= lg2(SW'(cfg_banks)); c_rb <= lg2(SW'(cfg_ranks));
        c_start <= cfg_start; c_span <= cfg_end - cfg_start; c_used <= cfg_banks_used;
        c_n <= cfg_seq_len; c_colmax <= l_cols - cfg_seq_len; c_pct <= cfg_read_pct;
        c_lay <= cfg_layout; cfg_err <= l_bad;
        st <= l_bad ? S_IDLE : S_RW;
      end else begin
        case (st)
          S_RW:
            if (c_pct == '0) begin wr <= 1'b1; st <= S_BANK; end
            else if (c_pct >= 7'd100) begin wr <= 1'b0; st <= S_BANK; end
            else if (lfsr[6:0] <= 7'd100) begin wr <= (lfsr[6:0] >= c_pct); st <= S_BANK; end
          S_BANK:
            if ((rnd & kmask) < AW'(c_used)) begin d_bank <= rnd & kmask; st <= S_RANK; end
          S_RANK: begin d_rank <= rnd & rmask; st <= S_BASE; end
          S_BASE:
            if ((rnd & smask) <= c_span) begin d_base <= c_start + (rnd & smask); st <= S_COL; end
          S_COL:
            if ((rnd & colmask) <= AW'(c_colmax)) begin
              addr <= first_addr; left <= c_n; st <= S_EMIT;
            end
          S_EMIT:
            if (req_ready) begin
              left <= left - SW'(1);
              if (left == SW'(1)) st <= S_RW;
              else addr <= next_addr;
            end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  logic [AW-1:0] a_bank;
  assign a_bank = (req_addr >> bankpos) & kmask;

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready && !cfg_load |=> req_valid && $stable(req_addr) && $stable(req_write));
  p_bytes_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> bytes_total == $past(bytes_total) + CW'($past(req_size)));
  p_err_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !req_valid);
  p_bank_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> a_bank < AW'(c_used));
  p_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_addr & AW'(req_size - SW'(1))) == '0);

endmodule

// File: tb/test_dram_hit_gen.sv
`timescale 1ns/1ps
module test_dram_hit_gen;
  localparam int AW = 32, SW = 16, BKW = 8, CW = 48;

  logic clk = 0, rst_n = 0, cfg_load = 0, cfg_layout = 0, req_ready = 0;
  logic [AW-1:0] cfg_start = 0, cfg_end = 0;
  logic [SW-1:0] cfg_block_bytes = 0, cfg_page_bytes = 0, cfg_seq_len = 0;
  logic [BKW-1:0] cfg_banks = 0, cfg_banks_used = 0, cfg_ranks = 0;
  logic [6:0] cfg_read_pct = 0;
  logic cfg_err, req_valid, req_write;
  logic [AW-1:0] req_addr;
  logic [SW-1:0] req_size;
  logic [CW-1:0] bytes_total;

  dram_hit_gen i_dram_hit_gen (.*);

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  int blk, n, nu, nr, pct, bb, cb, kb, rb, cols, colpos, bankpos, rankpos;
  int ref_left = 0, rdy_mode = 0, hold_off = 0, nhs = 0, nrd = 0, nwr = 0;
  bit prev_stall = 0, ref_write = 0, prev_write = 0, r12_pending = 0;
  longint ref_bytes = 0, ref_addr = 0, prev_addr = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic observe();
    longint a;
    int col, bank, rank;
    chk(bytes_total == ref_bytes, "R10 bytes_total", bytes_total, ref_bytes);
    if (prev_stall)
      chk(req_valid && req_addr == prev_addr && req_write == prev_write, "R11 hold",
          req_addr, prev_addr);
    if (req_valid && req_ready) begin
      a = req_addr;
      col  = int'((a >> colpos) % cols);
      bank = int'((a >> bankpos) % (1 << kb));
      rank = int'((a >> rankpos) % (1 << rb));
      nhs++;
      ref_bytes += blk;
      chk(req_size == blk, "R10 size", req_size, blk);
      if (r12_pending) begin
        chk(req_write == 1, "R12 new series after reload", req_write, 1);
        r12_pending = 0;
      end
      if (ref_left == 0) begin
        chk(a % blk == 0, lay_tag(), a % blk, 0);
        chk(bank < nu, "R4 bank range", bank, nu - 1);
        chk(rank < nr, "R5 rank range", rank, nr - 1);
        chk(col <= cols - n, "R6 start column", col, cols - n);
        if (pct == 0)   chk(req_write == 1, "R3 pct 0", req_write, 1);
        if (pct == 100) chk(req_write == 0, "R3 pct 100", req_write, 0);
        if (req_write) nwr++; else nrd++;
        ref_write = req_write;
        ref_left = n - 1;
      end else begin
        chk(a == ref_addr + (longint'(1) << colpos), {lay_tag(), " R9 next column"},
            a, ref_addr + (longint'(1) << colpos));
        chk(req_write == ref_write, "R2 direction within series", req_write, ref_write);
        ref_left--;
      end
      ref_addr = a;
    end
    prev_stall = req_valid && !req_ready;
    prev_addr  = req_addr;
    prev_write = req_write;
  endtask

  function automatic string lay_tag();
    return cfg_layout ? "R8 layout1" : "R7 layout0";
  endfunction

  task automatic step();
    @(negedge clk);
    cyc++;
    req_ready = hold_off ? 1'b0 : (rdy_mode == 0 ? 1'b1 : (cyc % 3 != 0));
    if (rst_n) observe();
  endtask

  task automatic load(input int l, input int b, input int p, input int banks, input int used,
                      input int ranks, input int nn, input int pc);
    hold_off = 1;
    step();
    cfg_layout = l[0]; cfg_block_bytes = SW'(b); cfg_page_bytes = SW'(p);
    cfg_banks = BKW'(banks); cfg_banks_used = BKW'(used); cfg_ranks = BKW'(ranks);
    cfg_seq_len = SW'(nn); cfg_read_pct = 7'(pc);
    cfg_start = 32'h1000_0000; cfg_end = 32'h1FFF_FFFF;
    blk = b; n = nn; nu = used; nr = ranks; pct = pc;
    bb = $clog2(b); cols = p / b; cb = $clog2(cols); kb = $clog2(banks); rb = $clog2(ranks);
    colpos  = l != 0 ? bb + kb + rb : bb;
    bankpos = l != 0 ? bb : bb + cb;
    rankpos = l != 0 ? bb + kb : bb + cb + kb;
    cfg_load = 1; prev_stall = 0; ref_left = 0;
    step();
    cfg_load = 0; hold_off = 0;
  endtask

  task automatic run(input int k);
    for (int i = 0; i < k; i++) step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 10; i++) begin
      step();
      chk(!req_valid && bytes_total == 0 && !cfg_err, "R1 reset and idle", req_valid, 0);
    end

    rdy_mode = 0; nhs = 0;
    load(0, 32, 1024, 8, 5, 2, 6, 100);
    chk(!cfg_err, "R4 legal config", cfg_err, 0);
    run(400);
    chk(nhs > 20, "R2 layout0 traffic", nhs, 21);
    while (ref_left == 0) step();
    load(0, 32, 1024, 8, 5, 2, 6, 0);
    r12_pending = 1;
    run(200);
    chk(!r12_pending, "R12 request after reload", r12_pending, 0);

    rdy_mode = 1; nhs = 0;
    load(1, 64, 2048, 16, 16, 4, 32, 0);
    run(1500);
    chk(nhs > 64, "R6 full-page series", nhs, 65);

    rdy_mode = 1; nhs = 0; nrd = 0; nwr = 0;
    load(0, 16, 256, 4, 3, 1, 1, 50);
    run(1500);
    chk(nrd > 0 && nwr > 0, "R3 mixed directions", nrd, nwr);

    load(1, 32, 1024, 8, 9, 2, 4, 50);
    for (int i = 0; i < 50; i++) begin
      step();
      chk(cfg_err && !req_valid, "R4 too many banks", cfg_err, 1);
    end
    load(0, 32, 512, 8, 8, 2, 17, 50);
    for (int i = 0; i < 30; i++) begin
      step();
      chk(cfg_err && !req_valid, "R4 series longer than page", cfg_err, 1);
    end
    nhs = 0; rdy_mode = 0;
    load(1, 32, 512, 8, 8, 2, 16, 30);
    run(400);
    chk(!cfg_err && nhs > 0, "R4 recovery after legal load", nhs, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20ns * 150000);
    checks++; errors++;
    $display("FAIL R1 watchdog expired at cycle %0d", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule